// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block is the translation lookaside cache for one memory-management unit. A lookup presents a 32-bit logical address together with its privilege space and access direction. One clock later the block answers with a hit, a miss or a protection fault. On a hit it also returns the 32-bit physical address, a 2-bit user-defined physical extension and a 2-bit caching mode. Storage is 4 ways of 16 sets, 64 entries in all. A table walker outside the block loads entries through a fill port. Two flush strobes clear either every entry or only the entries not marked global.

Pages are 4 KB or 8 KB, chosen at run time. The choice moves the set-index and page-number boundaries up by one bit. Each entry is tagged with its privilege space and carries supervisor-only and write-protect attributes, which are checked on every lookup. An external disable pin makes lookups skip the entries and return the logical address unchanged. Instruction fetch and data access each use a separate instance.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid and no response is produced. A lookup on the empty cache answers miss: hit=0, fault=0, with physical address, extension and mode all zero.
- R2: A lookup accepted at one rising edge produces rsp_valid at the next edge and not otherwise. On a hit, the physical address is the stored physical page number joined with the page offset of the logical address, and the stored extension and mode are returned with it.
- R3: A lookup misses (hit=0, fault=0, data zero) when no valid entry in its set has the same page number and the same privilege space (req_super equal to the entry's fill_super).
- R4: With page_8k=0 the page offset is bits 11:0 and the set index is bits 15:12. With page_8k=1 the offset is bits 12:0 and the set index is bits 16:13. Logical bit 12 then belongs to the offset, and physical bit 12 is taken from the logical address.
- R5: A fill whose page is not already present writes the way named by that set's round-robin pointer, then advances the pointer (0,1,2,3,0...). The fifth distinct page filled into one set therefore replaces the first.
- R6: A fill whose page number and space match a valid entry in the set overwrites that way and leaves the set's pointer unchanged. No duplicate entry is created.
- R7: A user lookup (req_super=0) that matches an entry filled with fill_sprot=1 returns fault=1 and hit=0.
- R8: A write lookup (req_write=1) that matches an entry filled with fill_wprot=1 returns fault=1 and hit=0. A read of the same entry hits.
- R9: flush_nonglobal invalidates every entry filled with fill_global=0 and keeps entries filled with fill_global=1.
- R10: flush_all invalidates every entry in one cycle, whatever the global bit.
- R11: While xlate_off=1, a lookup returns hit=1 and fault=0, with the physical address equal to the logical address and extension and mode zero. The entries are not consulted.
- R12: A fill presented in the same cycle as either flush strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_off | input | 1 | Bypass translation (identity mapping) |
| page_8k | input | 1 | 0: 4 KB pages, 1: 8 KB pages |
| req_valid | input | 1 | Lookup request strobe |
| req_la | input | 32 | Lookup logical address |
| req_super | input | 1 | Lookup privilege space: 1 supervisor, 0 user |
| req_write | input | 1 | Lookup is a write |
| fill_valid | input | 1 | Fill strobe from the table walker |
| fill_la | input | 32 | Logical address of the page being filled |
| fill_pa | input | 32 | Physical address of the page being filled |
| fill_super | input | 1 | Privilege space of the filled entry |
| fill_global | input | 1 | Entry survives flush_nonglobal |
| fill_sprot | input | 1 | Entry is supervisor-only |
| fill_wprot | input | 1 | Entry is write-protected |
| fill_mode | input | 2 | Caching mode stored with the entry |
| fill_ext | input | 2 | Physical extension stored with the entry |
| flush_all | input | 1 | Invalidate all entries |
| flush_nonglobal | input | 1 | Invalidate non-global entries |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Translation found but access not permitted |
| rsp_pa | output | 32 | Physical address |
| rsp_ext | output | 2 | Physical extension |
| rsp_mode | output | 2 | Caching mode |

## Verification
The only output with timing is the lookup response. It is registered, so it is due at the first rising edge after the request edge. Fills and flushes change the contents at their own edge, so a lookup in the following cycle already sees them. The driver applies each stimulus at a falling edge and, for a lookup, pushes the expected response computed from a bench-side model of the contents. The monitor pops and compares at the next falling edge, which is half a period after the response register loads. Eviction order and the R12 drop are checked only through later lookups. After the last request the bench also confirms that no expected item is left waiting.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_OFF = 12;
  localparam int VPN_W    = ADDR_W - BASE_OFF;
  localparam int EXT_W    = 2;
  localparam int MODE_W   = 2;

  typedef logic [VPN_W-1:0]  vpn_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic              space;
    logic              sprot;
    logic              wprot;
    logic [MODE_W-1:0] mode;
    logic [EXT_W-1:0]  ext;
    vpn_t              vpn;
    vpn_t              ppn;
  } entry_t;

  // Page number of an address: shift out the page offset.
  function automatic vpn_t page_number(input addr_t a, input logic big);
    addr_t sh;
    sh = a >> (BASE_OFF + int'(big));
    return sh[VPN_W-1:0];
  endfunction

  function automatic addr_t offset_mask(input logic big);
    return (addr_t'(1) << (BASE_OFF + int'(big))) - addr_t'(1);
  endfunction

  // Physical address: page frame bits from the entry, offset from the lookup.
  function automatic addr_t join_pa(input vpn_t ppn, input addr_t a, input logic big);
    addr_t m;
    m = offset_mask(big);
    return ({ppn, {BASE_OFF{1'b0}}} & ~m) | (a & m);
  endfunction

  function automatic logic prot_fail(input entry_t e, input logic sup, input logic wr);
    return (e.sprot && !sup) || (e.wprot && wr);
  endfunction
endpackage

// File: rtl/xlate_way.sv
module xlate_way
  import xlate_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  vpn_t             lk_vpn,
  input  logic             lk_space,
  input  logic [SET_W-1:0] fl_set,
  input  vpn_t             fl_vpn,
  input  logic             fl_space,
  input  logic             wr_en,
  input  logic             wr_glob,
  input  entry_t           wr_data,
  input  logic             flush_all,
  input  logic             flush_ng,
  output entry_t           lk_data,
  output logic             lk_match,
  output logic             fl_match,
  output logic [SETS-1:0]  vld_o,
  output logic [SETS-1:0]  glb_o
);
  entry_t          mem [SETS];
  logic [SETS-1:0] vld;
  logic [SETS-1:0] glb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      glb <= '0;
    end else if (flush_all) begin
      vld <= '0;
    end else if (flush_ng) begin
      vld <= vld & glb;
    end else if (wr_en) begin
      vld[fl_set] <= 1'b1;
      glb[fl_set] <= wr_glob;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[fl_set] <= wr_data;
  end

  assign lk_data  = mem[lk_set];
  assign lk_match = vld[lk_set] && (mem[lk_set].vpn == lk_vpn) && (mem[lk_set].space == lk_space);
  assign fl_match = vld[fl_set] && (mem[fl_set].vpn == fl_vpn) && (mem[fl_set].space == fl_space);
  assign vld_o    = vld;
  assign glb_o    = glb;
endmodule

// File: rtl/xlate_repl.sv
module xlate_repl #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = $clog2(WAYS),
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [SET_W-1:0] set,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) ptr[i] <= '0;
    end else if (adv) begin
      ptr[set] <= (ptr[set] == WAY_W'(WAYS-1)) ? '0 : ptr[set] + 1'b1;
    end
  end

  assign victim = ptr[set];
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_off,
  input  logic              page_8k,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_la,
  input  logic              req_super,
  input  logic              req_write,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_la,
  input  logic [ADDR_W-1:0] fill_pa,
  input  logic              fill_super,
  input  logic              fill_global,
  input  logic              fill_sprot,
  input  logic              fill_wprot,
  input  logic [MODE_W-1:0] fill_mode,
  input  logic [EXT_W-1:0]  fill_ext,
  input  logic              flush_all,
  input  logic              flush_nonglobal,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [EXT_W-1:0]  rsp_ext,
  output logic [MODE_W-1:0] rsp_mode
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  // Lookup and fill keys
  vpn_t             lk_vpn, fl_vpn;
  logic [SET_W-1:0] lk_set, fl_set;
  assign lk_vpn = page_number(req_la, page_8k);
  assign fl_vpn = page_number(fill_la, page_8k);
  assign lk_set = lk_vpn[SET_W-1:0];
  assign fl_set = fl_vpn[SET_W-1:0];

  // Events brought out for the checker
  logic [WAYS-1:0]      lk_match, fl_match, wr_en;
  logic [WAYS*SETS-1:0] vld_flat, glb_flat;
  logic                 flush_any, fill_take, fill_hit, lk_hit;

  entry_t           lk_data [WAYS];
  entry_t           sel, new_ent;
  logic [WAY_W-1:0] victim, fill_way;

  assign flush_any = flush_all || flush_nonglobal;
  assign fill_take = fill_valid && !flush_any;
  assign fill_hit  = |fl_match;
  assign lk_hit    = |lk_match;

  assign new_ent = '{space: fill_super, sprot: fill_sprot, wprot: fill_wprot,
                     mode: fill_mode, ext: fill_ext, vpn: fl_vpn,
                     ppn: page_number(fill_pa, 1'b0)};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wr_en[w] = fill_take && (fill_way == WAY_W'(w));
    xlate_way #(.SETS(SETS), .SET_W(SET_W)) u_way (
      .clk(clk), .rst_n(rst_n),
      .lk_set(lk_set), .lk_vpn(lk_vpn), .lk_space(req_super),
      .fl_set(fl_set), .fl_vpn(fl_vpn), .fl_space(fill_super),
      .wr_en(wr_en[w]), .wr_glob(fill_global), .wr_data(new_ent),
      .flush_all(flush_all), .flush_ng(flush_nonglobal),
      .lk_data(lk_data[w]), .lk_match(lk_match[w]), .fl_match(fl_match[w]),
      .vld_o(vld_flat[w*SETS +: SETS]), .glb_o(glb_flat[w*SETS +: SETS])
    );
  end

  xlate_repl #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_repl (
    .clk(clk), .rst_n(rst_n),
    .adv(fill_take && !fill_hit), .set(fl_set), .victim(victim)
  );

  // Way selection: matching way on refill, otherwise the round-robin victim
  always_comb begin
    fill_way = victim;
    for (int w = 0; w < WAYS; w++) if (fl_match[w]) fill_way = WAY_W'(w);
  end

  always_comb begin
    sel = '0;
    for (int w = 0; w < WAYS; w++) if (lk_match[w]) sel = lk_data[w];
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_ext   <= '0;
      rsp_mode  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_ext   <= '0;
      rsp_mode  <= '0;
      if (req_valid) begin
        if (xlate_off) begin
          rsp_hit <= 1'b1;
          rsp_pa  <= req_la;
        end else if (lk_hit) begin
          if (prot_fail(sel, req_super, req_write)) begin
            rsp_fault <= 1'b1;
          end else begin
            rsp_hit  <= 1'b1;
            rsp_pa   <= join_pa(sel.ppn, req_la, page_8k);
            rsp_ext  <= sel.ext;
            rsp_mode <= sel.mode;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 xlate_off,
  input logic                 req_valid,
  input logic [31:0]          req_la,
  input logic                 flush_all,
  input logic                 flush_nonglobal,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic                 rsp_fault,
  input logic [31:0]          rsp_pa,
  input logic [WAYS-1:0]      lk_match,
  input logic [WAYS-1:0]      fl_match,
  input logic [WAYS*SETS-1:0] vld_flat,
  input logic [WAYS*SETS-1:0] glb_flat
);
  p_resp_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hit_or_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_fault));
  p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlate_off) |=> (rsp_hit && !rsp_fault && rsp_pa == $past(req_la)));
  p_single_lookup_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_single_fill_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_match));
  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld_flat == '0));
  p_flush_ng_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_nonglobal && !flush_all) |=> ((vld_flat & ~glb_flat) == '0));
endmodule

bind xlate_cache xlate_cache_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlate_off(xlate_off), .req_valid(req_valid),
  .req_la(req_la), .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
  .lk_match(lk_match), .fl_match(fl_match), .vld_flat(vld_flat), .glb_flat(glb_flat)
);

// File: tb/tb_xlate_cache.sv
module tb_xlate_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xlate_off = 0, page_8k = 0;
  logic req_valid = 0, req_super = 0, req_write = 0;
  logic [31:0] req_la = '0, fill_la = '0, fill_pa = '0;
  logic fill_valid = 0, fill_super = 0, fill_global = 0, fill_sprot = 0, fill_wprot = 0;
  logic [1:0] fill_mode = '0, fill_ext = '0;
  logic flush_all = 0, flush_nonglobal = 0;
  logic rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_pa;
  logic [1:0] rsp_ext, rsp_mode;

  always #2 clk = ~clk;

  xlate_cache dut (.*);

  typedef struct {bit hit, fault; logic [31:0] pa; logic [1:0] ext, mode; string req;} exp_t;
  typedef struct {bit v, s, g, sp, wp; logic [1:0] mode, ext; logic [19:0] vpn, ppn;} ment_t;
  exp_t  q[$];
  ment_t m [16][4];
  int    rr [16];
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  function automatic logic [19:0] b_vpn(input logic [31:0] a);
    return page_8k ? {1'b0, a[31:13]} : a[31:12];
  endfunction
  function automatic int b_set(input logic [31:0] a);
    return page_8k ? int'(a[16:13]) : int'(a[15:12]);
  endfunction

  task automatic quiet();
    req_valid = 0; fill_valid = 0; flush_all = 0; flush_nonglobal = 0; xlate_off = 0;
  endtask

  task automatic lookup(input logic [31:0] la, input bit sup, input bit wr, input bit off, input string req);
    exp_t e;
    int s;
    @(negedge clk); quiet();
    req_valid = 1; req_la = la; req_super = sup; req_write = wr; xlate_off = off;
    e = '{0, 0, 32'h0, 2'b0, 2'b0, req};
    s = b_set(la);
    if (off) begin
      e.hit = 1; e.pa = la;
    end else begin
      for (int w = 0; w < 4; w++)
        if (m[s][w].v && m[s][w].vpn == b_vpn(la) && m[s][w].s == sup) begin
          if ((m[s][w].sp && !sup) || (m[s][w].wp && wr)) e.fault = 1;
          else begin
            e.hit = 1; e.ext = m[s][w].ext; e.mode = m[s][w].mode;
            e.pa = page_8k ? {m[s][w].ppn[19:1], la[12:0]} : {m[s][w].ppn, la[11:0]};
          end
        end
    end
    q.push_back(e);
  endtask

  task automatic fill(input logic [31:0] la, input logic [31:0] pa, input bit sup, input bit g,
                      input bit sp, input bit wp, input logic [1:0] mo, input logic [1:0] ex);
    int s, w;
    @(negedge clk); quiet();
    fill_valid = 1; fill_la = la; fill_pa = pa; fill_super = sup; fill_global = g;
    fill_sprot = sp; fill_wprot = wp; fill_mode = mo; fill_ext = ex;
    s = b_set(la); w = -1;
    for (int i = 0; i < 4; i++) if (m[s][i].v && m[s][i].vpn == b_vpn(la) && m[s][i].s == sup) w = i;
    if (w < 0) begin w = rr[s]; rr[s] = (rr[s] + 1) % 4; end
    m[s][w] = '{1, sup, g, sp, wp, mo, ex, b_vpn(la), pa[31:12]};
  endtask

  // R12: optional fill in the same cycle as the flush, which the model drops
  task automatic flush(input bit all, input bit with_fill, input logic [31:0] la);
    @(negedge clk); quiet();
    flush_all = all; flush_nonglobal = !all;
    if (with_fill) begin
      fill_valid = 1; fill_la = la; fill_pa = 32'h7777_7000; fill_super = 0; fill_global = 1;
      fill_sprot = 0; fill_wprot = 0;
    end
    for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) if (all || !m[s][w].g) m[s][w].v = 0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_run++;
      if (q.size() == 0) begin
        n_fail++; $display("FAIL R2 unexpected response: actual=rsp_valid expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_hit !== e.hit || rsp_fault !== e.fault || rsp_pa !== e.pa ||
            rsp_ext !== e.ext || rsp_mode !== e.mode) begin
          n_fail++;
          $display("FAIL %s actual hit=%0d fault=%0d pa=%h ext=%0d mode=%0d expected hit=%0d fault=%0d pa=%h ext=%0d mode=%0d",
                   e.req, rsp_hit, rsp_fault, rsp_pa, rsp_ext, rsp_mode, e.hit, e.fault, e.pa, e.ext, e.mode);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      rr[s] = 0;
      for (int w = 0; w < 4; w++) m[s][w] = '{0, 0, 0, 0, 0, 2'b0, 2'b0, 20'h0, 20'h0};
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    n_run++;
    if (rsp_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1 reset: actual rsp_valid=%b expected 0", rsp_valid);
    end
    lookup(32'h1234_5678, 0, 0, 0, "R1 empty");

    // R2/R3: 4 KB pages
    fill(32'h1234_5000, 32'hABCD_E000, 0, 0, 0, 0, 2'd2, 2'd1);
    lookup(32'h1234_5678, 0, 0, 0, "R2 hit");
    lookup(32'h1234_5FFF, 0, 1, 0, "R2 hit write");
    lookup(32'h1234_5678, 1, 0, 0, "R3 other space");
    lookup(32'h9234_5678, 0, 0, 0, "R3 other tag");

    // R7/R8: protection
    fill(32'h0000_3000, 32'h0003_3000, 0, 0, 1, 0, 2'd1, 2'd0);
    lookup(32'h0000_3010, 0, 0, 0, "R7 user on supervisor page");
    fill(32'h0000_3000, 32'h0004_3000, 1, 0, 1, 0, 2'd1, 2'd3);
    lookup(32'h0000_3010, 1, 0, 0, "R7 supervisor on supervisor page");
    fill(32'h0000_4000, 32'h0005_4000, 0, 0, 0, 1, 2'd3, 2'd2);
    lookup(32'h0000_4044, 0, 1, 0, "R8 write protected");
    lookup(32'h0000_4044, 0, 0, 0, "R8 read allowed");

    // R5: five pages into set 9
    for (int t = 1; t <= 5; t++)
      fill((32'(t) << 16) | 32'h9000, 32'h0100_0000 + (32'(t) << 12), 0, 0, 0, 0, 2'd0, 2'(t));
    for (int t = 1; t <= 5; t++) lookup((32'(t) << 16) | 32'h9abc, 0, 0, 0, "R5 round robin");

    // R6: refill in place, then a new page takes the unmoved pointer
    fill(32'h0003_9000, 32'h0F00_0000, 0, 0, 0, 0, 2'd1, 2'd1);
    fill(32'h0006_9000, 32'h0E00_0000, 0, 0, 0, 0, 2'd2, 2'd2);
    lookup(32'h0003_9004, 0, 0, 0, "R6 refilled page");
    lookup(32'h0002_9004, 0, 0, 0, "R6 evicted page");
    lookup(32'h0004_9004, 0, 0, 0, "R6 kept page");
    lookup(32'h0006_9004, 0, 0, 0, "R6 new page");

    // R11: bypass
    lookup(32'hDEAD_BEEF, 0, 1, 1, "R11 bypass");
    lookup(32'h1234_5678, 1, 0, 1, "R11 bypass over entry");

    // R10: flush all
    flush(1, 0, 32'h0);
    lookup(32'h1234_5678, 0, 0, 0, "R10 flushed");
    lookup(32'h0000_4044, 0, 0, 0, "R10 flushed");

    // R4: 8 KB pages
    @(negedge clk); quiet(); page_8k = 1;
    fill(32'h00FF_E000, 32'h5555_6000, 0, 0, 0, 0, 2'd3, 2'd3);
    lookup(32'h00FF_F123, 0, 0, 0, "R4 8k offset bit 12");
    lookup(32'h00FF_E001, 0, 0, 0, "R4 8k low half");
    lookup(32'h00FE_F123, 0, 0, 0, "R4 8k other set");

    // R9: flush non-global
    fill(32'h0040_2000, 32'h0060_2000, 0, 1, 0, 0, 2'd1, 2'd2);
    fill(32'h0080_2000, 32'h00A0_2000, 0, 0, 0, 0, 2'd2, 2'd1);
    flush(0, 0, 32'h0);
    lookup(32'h0040_2100, 0, 0, 0, "R9 global kept");
    lookup(32'h0080_2100, 0, 0, 0, "R9 nonglobal gone");

    // R12: fill with concurrent flush is dropped
    flush(1, 1, 32'h0123_4000);
    lookup(32'h0123_4000, 0, 0, 0, "R12 fill dropped");
    lookup(32'h0040_2100, 0, 0, 0, "R12 R10 global flushed by all");

    @(negedge clk); quiet();
    repeat (3) @(negedge clk);
    n_run++;
    if (q.size() != 0) begin
      n_fail++; $display("FAIL R2 pending responses: actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule